// File: doc/BRIEF.md
# Dual-Bank Endpoint Buffer Manager

This block keeps track of the packet buffers behind the endpoints of a USB device controller. Every endpoint owns up to two buffer banks. A bank belongs either to the USB side or to the CPU side. In two-bank mode the serial engine fills or drains one bank while software works on the other. Ownership passes over when a packet ends and passes back when software releases the bank. The block holds no payload bytes. For every accepted byte it gives out the endpoint, bank and byte index, and the external packet RAM uses these as the address.

The serial engine opens a packet with a start strobe and an endpoint number. If the block refuses, it answers with a NAK in the same cycle. The engine then moves bytes over a valid/ready beat stream and closes the packet with an end strobe. A beat transfers only in a cycle where both `usb_valid` and `usb_ready` are high. The engine may hold `usb_valid` high for any length of time, and `usb_ready` never depends on `usb_valid`. On the CPU side, software picks an endpoint and reads back, as plain status, the ownership of each bank, the byte count and overflow flag of each bank, and the bank the USB side will use next. A release command returns a bank to the USB side; for IN endpoints it also loads the byte count. A configuration write sets an endpoint's direction, bank mode and maximum packet size.

Top module: `ep_bank_mgr`

## Requirements
- R1: After reset every endpoint is OUT, single-bank, with size 1023. Both banks are USB-owned (`cpu_own` bit = 0), both counts and overflow flags are 0, and `cpu_next_bank` is 0. `usb_ready` is 0 while no packet is open.
- R2: Endpoint 0 always behaves as single-bank, whatever `cfg_dual` says. Its next bank stays 0, and a release of bank 1 on it has no effect.
- R3: A start is accepted only when the bank named by the endpoint's next-bank bit is USB-owned. Otherwise `usb_nak` is 1 in the same cycle as `usb_sop` and no packet opens. The block never moves to the other bank out of turn.
- R4: In an OUT packet, accepted beats raise `buf_en` with `buf_idx` counting 0,1,2,… on the packet's bank. At the end strobe the byte count is stored in that bank, the bank becomes CPU-owned (`cpu_own` bit = 1), and in two-bank mode the next-bank bit inverts.
- R5: OUT beats beyond the endpoint size are still accepted (`usb_ready` = 1) but are discarded (`buf_en` = 0). At the end strobe the bank's overflow flag is set and its count equals the size.
- R6: A release of a CPU-owned bank makes it USB-owned and clears its overflow flag. On an IN endpoint it also loads the count from `cpu_rel_cnt`, clamped to the endpoint size. A release of a USB-owned bank changes nothing.
- R7: An IN endpoint starts with its banks CPU-owned. An IN start is accepted only for a released bank, and `usb_in_len` then shows that bank's count. `usb_ready` stays 1 for exactly that many beats, with `buf_idx` counting from 0.
- R8: At the end of an IN packet the bank returns to the CPU side and, in two-bank mode, the next-bank bit inverts. Banks are therefore sent in strict alternation.
- R9: A configuration write resets the endpoint: next bank 0, counts and flags 0, OUT banks USB-owned, IN banks CPU-owned. It also closes any packet open on that endpoint (`usb_ready` = 0 in that cycle), and that packet commits nothing.
- R10: `usb_ready` is 0 in the end-strobe cycle and after the packet closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ep | input | 3 | Endpoint to configure |
| cfg_dual | input | 1 | 1 = two banks |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT |
| cfg_size | input | 10 | Maximum packet size in bytes |
| usb_sop | input | 1 | Packet start strobe |
| usb_ep | input | 3 | Endpoint of the starting packet |
| usb_nak | output | 1 | Start refused (combinational) |
| usb_valid | input | 1 | Beat valid from serial engine |
| usb_ready | output | 1 | Beat can transfer |
| usb_eop | input | 1 | Packet end strobe |
| usb_in_len | output | 10 | Byte count of the open IN packet |
| buf_en | output | 1 | Packet RAM access strobe |
| buf_ep | output | 3 | Packet RAM endpoint |
| buf_bank | output | 1 | Packet RAM bank |
| buf_idx | output | 10 | Packet RAM byte index |
| cpu_ep | input | 3 | Endpoint selected by software |
| cpu_rel | input | 1 | Release command strobe |
| cpu_rel_bank | input | 1 | Bank to release |
| cpu_rel_cnt | input | 10 | Byte count loaded on IN release |
| cpu_own | output | 2 | Per-bank ownership, 1 = CPU |
| cpu_cnt0 | output | 10 | Byte count of bank 0 |
| cpu_cnt1 | output | 10 | Byte count of bank 1 |
| cpu_ovf | output | 2 | Per-bank overflow flags |
| cpu_next_bank | output | 1 | Bank the USB side uses next |

## Verification
`usb_nak`, `usb_ready`, `buf_en`, `buf_bank` and `buf_idx` are combinational. They answer in the cycle that the start strobe or beat is presented. The bench drives each stimulus 1 ns after a rising edge and samples these outputs 1 ns later, before the next edge. A start, end strobe, release or configuration write takes effect at the following rising edge. So `cpu_own`, the counts, the flags, `cpu_next_bank` and `usb_in_len` are checked only after that edge has passed. Expected counts, banks and indices come from running totals kept in the bench.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;
  typedef enum logic {DIR_OUT = 1'b0, DIR_IN = 1'b1} ep_dir_e;

  typedef struct packed {
    logic    dual;
    ep_dir_e dir;
  } ep_mode_t;
endpackage

// File: rtl/ep_slot.sv
module ep_slot
  import ep_bank_pkg::*;
#(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned MAX_PKT     = 1023,
  parameter bit          SINGLE_ONLY = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  ep_mode_t              cfg_mode,
  input  logic [CNT_W-1:0]      cfg_size,
  input  logic                  commit,
  input  logic [CNT_W-1:0]      commit_cnt,
  input  logic                  commit_ovf,
  input  logic                  rel,
  input  logic                  rel_bank,
  input  logic [CNT_W-1:0]      rel_cnt,
  output ep_mode_t              mode,
  output logic [CNT_W-1:0]      size,
  output logic [1:0]            own,
  output logic [1:0][CNT_W-1:0] cnt,
  output logic [1:0]            ovf,
  output logic                  tog
);
  localparam logic [CNT_W-1:0] SizeCap = CNT_W'(MAX_PKT);

  ep_mode_t              mode_q;
  logic [CNT_W-1:0]      size_q;
  logic [1:0]            own_q;
  logic [1:0][CNT_W-1:0] cnt_q;
  logic [1:0]            ovf_q;
  logic                  tog_q;

  logic             rel_ok;
  logic [CNT_W-1:0] rel_clamped;
  logic [CNT_W-1:0] cfg_clamped;

  assign rel_ok      = rel && own_q[rel_bank] && (!rel_bank || mode_q.dual);
  assign rel_clamped = (rel_cnt > size_q) ? size_q : rel_cnt;
  assign cfg_clamped = (cfg_size > SizeCap) ? SizeCap : cfg_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '{dual: 1'b0, dir: DIR_OUT};
      size_q <= SizeCap;
      own_q  <= '0;
      cnt_q  <= '0;
      ovf_q  <= '0;
      tog_q  <= 1'b0;
    end else if (cfg_we) begin
      mode_q.dual <= cfg_mode.dual && !SINGLE_ONLY;
      mode_q.dir  <= cfg_mode.dir;
      size_q      <= cfg_clamped;
      own_q       <= (cfg_mode.dir == DIR_IN) ? {cfg_mode.dual && !SINGLE_ONLY, 1'b1} : 2'b00;
      cnt_q       <= '0;
      ovf_q       <= '0;
      tog_q       <= 1'b0;
    end else begin
      if (commit) begin
        own_q[tog_q] <= 1'b1;
        if (mode_q.dir == DIR_OUT) begin
          cnt_q[tog_q] <= commit_cnt;
          ovf_q[tog_q] <= commit_ovf;
        end
        if (mode_q.dual) tog_q <= ~tog_q;
      end
      if (rel_ok) begin
        own_q[rel_bank] <= 1'b0;
        ovf_q[rel_bank] <= 1'b0;
        if (mode_q.dir == DIR_IN) cnt_q[rel_bank] <= rel_clamped;
      end
    end
  end

  assign mode = mode_q;
  assign size = size_q;
  assign own  = own_q;
  assign cnt  = cnt_q;
  assign ovf  = ovf_q;
  assign tog  = tog_q;

  // R2
  single_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.dual |-> !tog_q);
  // R4
  commit_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !cfg_we && !tog_q |=> own_q[0]);
  // R4
  commit_bank1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !cfg_we && tog_q |=> own_q[1]);
  // R8
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !cfg_we && mode_q.dual |=> tog_q != $past(tog_q));
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[0] <= size_q && cnt_q[1] <= size_q);
endmodule

// File: rtl/ep_pkt_ctrl.sv
module ep_pkt_ctrl
  import ep_bank_pkg::*;
#(
  parameter int unsigned EP_W  = 3,
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usb_sop,
  input  logic [EP_W-1:0]  usb_ep,
  input  logic             sop_ok,
  input  ep_dir_e          sel_dir,
  input  logic             sel_bank,
  input  logic [CNT_W-1:0] sel_lim,
  input  logic             usb_valid,
  input  logic             usb_eop,
  input  logic             abort_req,
  output logic             usb_nak,
  output logic             usb_ready,
  output logic             open,
  output logic [EP_W-1:0]  pkt_ep,
  output logic             pkt_bank,
  output logic [CNT_W-1:0] pkt_idx,
  output logic [CNT_W-1:0] in_len,
  output logic             buf_en,
  output logic             commit,
  output logic [CNT_W-1:0] commit_cnt,
  output logic             commit_ovf
);
  logic             open_q;
  logic [EP_W-1:0]  ep_q;
  logic             bank_q;
  ep_dir_e          dir_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] idx_q;
  logic             ovf_q;

  logic start, under, drop, abort;

  assign abort     = open_q && abort_req;
  assign start     = usb_sop && !open_q && sop_ok;
  assign usb_nak   = usb_sop && !open_q && !sop_ok;
  assign under     = idx_q < lim_q;
  assign usb_ready = open_q && !usb_eop && !abort && ((dir_q == DIR_OUT) || under);
  assign buf_en    = usb_valid && usb_ready && under;
  assign drop      = usb_valid && usb_ready && !under;
  assign commit    = open_q && usb_eop && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ep_q   <= '0;
      bank_q <= 1'b0;
      dir_q  <= DIR_OUT;
      lim_q  <= '0;
      idx_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (start) begin
      open_q <= 1'b1;
      ep_q   <= usb_ep;
      bank_q <= sel_bank;
      dir_q  <= sel_dir;
      lim_q  <= sel_lim;
      idx_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (commit || abort) begin
      open_q <= 1'b0;
    end else begin
      if (buf_en) idx_q <= idx_q + 1'b1;
      if (drop)   ovf_q <= 1'b1;
    end
  end

  assign open       = open_q;
  assign pkt_ep     = ep_q;
  assign pkt_bank   = bank_q;
  assign pkt_idx    = idx_q;
  assign in_len     = (open_q && dir_q == DIR_IN) ? lim_q : '0;
  assign commit_cnt = idx_q;
  assign commit_ovf = ovf_q;

  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> idx_q <= lim_q);
  // R7
  in_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_q && dir_q == DIR_IN |-> !ovf_q);
  // R10
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || abort) |=> !open_q);
endmodule

// File: rtl/ep_bank_mgr.sv
module ep_bank_mgr
  import ep_bank_pkg::*;
#(
  parameter int unsigned NUM_EP  = 8,
  parameter int unsigned MAX_PKT = 1023
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [$clog2(NUM_EP)-1:0]    cfg_ep,
  input  logic                         cfg_dual,
  input  logic                         cfg_dir_in,
  input  logic [$clog2(MAX_PKT+1)-1:0] cfg_size,
  input  logic                         usb_sop,
  input  logic [$clog2(NUM_EP)-1:0]    usb_ep,
  output logic                         usb_nak,
  input  logic                         usb_valid,
  output logic                         usb_ready,
  input  logic                         usb_eop,
  output logic [$clog2(MAX_PKT+1)-1:0] usb_in_len,
  output logic                         buf_en,
  output logic [$clog2(NUM_EP)-1:0]    buf_ep,
  output logic                         buf_bank,
  output logic [$clog2(MAX_PKT+1)-1:0] buf_idx,
  input  logic [$clog2(NUM_EP)-1:0]    cpu_ep,
  input  logic                         cpu_rel,
  input  logic                         cpu_rel_bank,
  input  logic [$clog2(MAX_PKT+1)-1:0] cpu_rel_cnt,
  output logic [1:0]                   cpu_own,
  output logic [$clog2(MAX_PKT+1)-1:0] cpu_cnt0,
  output logic [$clog2(MAX_PKT+1)-1:0] cpu_cnt1,
  output logic [1:0]                   cpu_ovf,
  output logic                         cpu_next_bank
);
  localparam int unsigned EP_W  = $clog2(NUM_EP);
  localparam int unsigned CNT_W = $clog2(MAX_PKT + 1);

  ep_mode_t                           cfg_mode;
  ep_mode_t [NUM_EP-1:0]              s_mode;
  logic [NUM_EP-1:0][CNT_W-1:0]       s_size;
  logic [NUM_EP-1:0][1:0]             s_own;
  logic [NUM_EP-1:0][1:0][CNT_W-1:0]  s_cnt;
  logic [NUM_EP-1:0][1:0]             s_ovf;
  logic [NUM_EP-1:0]                  s_tog;

  logic             sop_ok, sel_tog, open, commit, commit_ovf;
  logic [CNT_W-1:0] sel_lim, commit_cnt;
  logic [EP_W-1:0]  pkt_ep;

  assign cfg_mode.dual = cfg_dual;
  assign cfg_mode.dir  = cfg_dir_in ? DIR_IN : DIR_OUT;

  assign sel_tog = s_tog[usb_ep];
  assign sop_ok  = !s_own[usb_ep][sel_tog] && !(cfg_we && cfg_ep == usb_ep);
  assign sel_lim = (s_mode[usb_ep].dir == DIR_IN) ? s_cnt[usb_ep][sel_tog] : s_size[usb_ep];

  for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
    ep_slot #(
      .CNT_W      (CNT_W),
      .MAX_PKT    (MAX_PKT),
      .SINGLE_ONLY(g == 0)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we && cfg_ep == EP_W'(g)),
      .cfg_mode  (cfg_mode),
      .cfg_size  (cfg_size),
      .commit    (commit && pkt_ep == EP_W'(g)),
      .commit_cnt(commit_cnt),
      .commit_ovf(commit_ovf),
      .rel       (cpu_rel && cpu_ep == EP_W'(g)),
      .rel_bank  (cpu_rel_bank),
      .rel_cnt   (cpu_rel_cnt),
      .mode      (s_mode[g]),
      .size      (s_size[g]),
      .own       (s_own[g]),
      .cnt       (s_cnt[g]),
      .ovf       (s_ovf[g]),
      .tog       (s_tog[g])
    );
  end

  ep_pkt_ctrl #(.EP_W(EP_W), .CNT_W(CNT_W)) u_pkt (
    .clk       (clk),
    .rst_n     (rst_n),
    .usb_sop   (usb_sop),
    .usb_ep    (usb_ep),
    .sop_ok    (sop_ok),
    .sel_dir   (s_mode[usb_ep].dir),
    .sel_bank  (sel_tog),
    .sel_lim   (sel_lim),
    .usb_valid (usb_valid),
    .usb_eop   (usb_eop),
    .abort_req (cfg_we && cfg_ep == pkt_ep),
    .usb_nak   (usb_nak),
    .usb_ready (usb_ready),
    .open      (open),
    .pkt_ep    (pkt_ep),
    .pkt_bank  (buf_bank),
    .pkt_idx   (buf_idx),
    .in_len    (usb_in_len),
    .buf_en    (buf_en),
    .commit    (commit),
    .commit_cnt(commit_cnt),
    .commit_ovf(commit_ovf)
  );

  assign buf_ep        = pkt_ep;
  assign cpu_own       = s_own[cpu_ep];
  assign cpu_cnt0      = s_cnt[cpu_ep][0];
  assign cpu_cnt1      = s_cnt[cpu_ep][1];
  assign cpu_ovf       = s_ovf[cpu_ep];
  assign cpu_next_bank = s_tog[cpu_ep];

  // R3
  nak_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_nak |=> $stable(open));
  // R10
  ready_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_ready |-> open);
endmodule

// File: tb/test_ep_bank_mgr.sv
module test_ep_bank_mgr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 0, cfg_dual = 0, cfg_dir_in = 0;
  logic [2:0] cfg_ep = 0, usb_ep = 0, cpu_ep = 0;
  logic [9:0] cfg_size = 0, cpu_rel_cnt = 0;
  logic       usb_sop = 0, usb_valid = 0, usb_eop = 0, cpu_rel = 0, cpu_rel_bank = 0;
  logic       usb_nak, usb_ready, buf_en, buf_bank, cpu_next_bank;
  logic [9:0] usb_in_len, buf_idx, cpu_cnt0, cpu_cnt1;
  logic [2:0] buf_ep;
  logic [1:0] cpu_own, cpu_ovf;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  ep_bank_mgr i_ep_bank_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_dual(cfg_dual),
    .cfg_dir_in(cfg_dir_in), .cfg_size(cfg_size), .usb_sop(usb_sop), .usb_ep(usb_ep),
    .usb_nak(usb_nak), .usb_valid(usb_valid), .usb_ready(usb_ready), .usb_eop(usb_eop),
    .usb_in_len(usb_in_len), .buf_en(buf_en), .buf_ep(buf_ep), .buf_bank(buf_bank),
    .buf_idx(buf_idx), .cpu_ep(cpu_ep), .cpu_rel(cpu_rel), .cpu_rel_bank(cpu_rel_bank),
    .cpu_rel_cnt(cpu_rel_cnt), .cpu_own(cpu_own), .cpu_cnt0(cpu_cnt0), .cpu_cnt1(cpu_cnt1),
    .cpu_ovf(cpu_ovf), .cpu_next_bank(cpu_next_bank)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int ep, input bit dual, input bit din, input int size);
    cfg_ep = 3'(ep); cfg_dual = dual; cfg_dir_in = din; cfg_size = 10'(size); cfg_we = 1;
    tick();
    cfg_we = 0;
  endtask

  task automatic rel(input int ep, input bit bank, input int cnt);
    cpu_ep = 3'(ep); cpu_rel_bank = bank; cpu_rel_cnt = 10'(cnt); cpu_rel = 1;
    tick();
    cpu_rel = 0;
  endtask

  task automatic view(input string req, input int ep, input int own, input int c0,
                      input int c1, input int ovf, input int nxt);
    cpu_ep = 3'(ep);
    #1;
    chk({req, " own"}, cpu_own, own);
    chk({req, " cnt0"}, cpu_cnt0, c0);
    chk({req, " cnt1"}, cpu_cnt1, c1);
    chk({req, " ovf"}, cpu_ovf, ovf);
    chk({req, " next"}, cpu_next_bank, nxt);
  endtask

  task automatic sop(input string req, input int ep, input bit exp_nak);
    usb_ep = 3'(ep); usb_sop = 1;
    #1 chk({req, " nak"}, usb_nak, exp_nak);
    tick();
    usb_sop = 0;
  endtask

  // OUT packet of n beats into endpoint of given size on expected bank
  task automatic out_pkt(input int ep, input int n, input int size, input bit bank);
    sop("R3", ep, 1'b0);
    for (int i = 0; i < n; i++) begin
      usb_valid = 1;
      #1;
      chk("R5 ready", usb_ready, 1);
      chk("R4/R5 buf_en", buf_en, (i < size) ? 1 : 0);
      if (i < size) begin
        chk("R4 idx", buf_idx, i);
        chk("R4 bank", buf_bank, bank);
        chk("R4 ep", buf_ep, ep);
      end
      tick();
      usb_valid = 0;
    end
    usb_eop = 1;
    #1 chk("R10 ready at eop", usb_ready, 0);
    tick();
    usb_eop = 0;
  endtask

  task automatic in_pkt(input int ep, input int len, input bit bank);
    sop("R7", ep, 1'b0);
    chk("R7 in_len", usb_in_len, len);
    for (int i = 0; i < len + 2; i++) begin
      usb_valid = 1;
      #1;
      chk("R7 ready", usb_ready, (i < len) ? 1 : 0);
      chk("R7 buf_en", buf_en, (i < len) ? 1 : 0);
      if (i < len) begin
        chk("R7 idx", buf_idx, i);
        chk("R7 bank", buf_bank, bank);
      end
      tick();
      usb_valid = 0;
    end
    usb_eop = 1;
    tick();
    usb_eop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int e0, e1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state of every endpoint
    for (int ep = 0; ep < 8; ep++) view("R1", ep, 0, 0, 0, 0, 0);
    chk("R1 idle ready", usb_ready, 0);

    // R2 endpoint 0 forced single, OUT size 8, length sweep (R4, R5)
    cfg(0, 1'b1, 1'b0, 8);
    for (int n = 0; n <= 11; n++) begin
      out_pkt(0, n, 8, 1'b0);
      view("R2/R4/R5", 0, 1, (n > 8) ? 8 : n, 0, (n > 8) ? 1 : 0, 0);
      chk("R10 closed", usb_ready, 0);
      sop("R3 ep0 busy", 0, 1'b1);
      rel(0, 1'b1, 0);
      view("R2 bank1 release ignored", 0, 1, (n > 8) ? 8 : n, 0, (n > 8) ? 1 : 0, 0);
      rel(0, 1'b0, 0);
      view("R6 out release", 0, 0, (n > 8) ? 8 : n, 0, 0, 0);
    end

    // Dual OUT endpoint 3, size 16: alternation and strict order (R3, R4, R5)
    cfg(3, 1'b1, 1'b0, 16);
    e0 = 0; e1 = 0;
    for (int k = 0; k < 6; k++) begin
      int n;
      n = k * 4;
      out_pkt(3, n, 16, 1'(k % 2));
      if (k % 2 == 0) e0 = (n > 16) ? 16 : n; else e1 = (n > 16) ? 16 : n;
      if (k % 2 == 0)
        view("R4 dual b0", 3, 1, e0, e1, (n > 16) ? 1 : 0, 1);
      else begin
        view("R4 dual b1", 3, 3, e0, e1, (n > 16) ? 2 : 0, 0);
        sop("R3 both busy", 3, 1'b1);
        rel(3, 1'b1, 0);
        sop("R3 strict order", 3, 1'b1);
        rel(3, 1'b0, 0);
        view("R6 both released", 3, 0, e0, e1, 0, 0);
      end
    end

    // IN endpoint 5, dual, size 32 (R6, R7, R8, R9)
    cfg(5, 1'b1, 1'b1, 32);
    view("R9 in init", 5, 3, 0, 0, 0, 0);
    sop("R7 unreleased", 5, 1'b1);
    rel(5, 1'b1, 5);
    view("R6 in release", 5, 1, 0, 5, 0, 0);
    sop("R8 strict alternation", 5, 1'b1);
    rel(5, 1'b0, 3);
    rel(5, 1'b0, 9);
    view("R6 usb-owned release ignored", 5, 0, 3, 5, 0, 0);
    in_pkt(5, 3, 1'b0);
    view("R8 in done b0", 5, 1, 3, 5, 0, 1);
    in_pkt(5, 5, 1'b1);
    view("R8 in done b1", 5, 3, 3, 5, 0, 0);
    rel(5, 1'b0, 40);
    view("R6 clamp", 5, 2, 32, 5, 0, 0);
    in_pkt(5, 32, 1'b0);
    rel(5, 1'b1, 0);
    in_pkt(5, 0, 1'b1);
    view("R8 zero length", 5, 3, 32, 0, 0, 0);

    // R9 configuration write aborts an open packet
    sop("R9 open", 3, 1'b0);
    for (int i = 0; i < 2; i++) begin
      usb_valid = 1;
      tick();
    end
    cfg_ep = 3; cfg_dual = 1; cfg_dir_in = 0; cfg_size = 16; cfg_we = 1;
    #1 chk("R9 ready during abort", usb_ready, 0);
    tick();
    cfg_we = 0;
    #1 chk("R9/R10 closed after abort", usb_ready, 0);
    usb_valid = 0;
    view("R9 reset state", 3, 0, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule